// File: doc/BRIEF.md
# Coprocessor Bus Access Interlock

This block stands on the CPU side of a graphics/math coprocessor register window. It watches each CPU request and drives a ready signal. The ready signal stays low while letting the request through could corrupt coprocessor state. A held request stays on the bus unchanged and completes in the first cycle in which nothing blocks it. Requests outside the window are never delayed.

Three hazards are enforced in hardware. The first is an access to a register that the surrounding decode flags as unsafe while the engine reports busy with sprite or math work. The second is a coprocessor access in the cycle right after another one. The third is any coprocessor access during the strobe cycle and the following `BLACKOUT_CYCLES` cycles after a cartridge write begins. Ordinary coprocessor writes are posted, so a cartridge write is the only case where a later access can damage an earlier one. The unsafe rule covers reads and writes alike, so the block takes no direction input.

Top module: `cop_bus_interlock`

## Requirements
- R1: After reset, no gap and no blackout is pending: a window access with the engine idle sees `cpu_ready` high in the first cycle after reset is released.
- R2: A window access with `unsafe_sel` high while `eng_busy` is high sees `cpu_ready` low in every cycle in which both inputs stay high.
- R3: `eng_busy` high with `unsafe_sel` low does not stall a window access, and neither does `unsafe_sel` high with `eng_busy` low.
- R4: After a window access is accepted (`cpu_valid` and `cpu_ready` high at a rising edge), a window access in the next cycle sees `cpu_ready` low. In the cycle after that it sees `cpu_ready` high again, provided nothing else blocks it.
- R5: A window access sees `cpu_ready` low in the cycle in which `cart_wr_go` is high and in each of the following 12 cycles. It sees `cpu_ready` high in the 13th cycle after the strobe.
- R6: A `cart_wr_go` strobe that arrives while a blackout is running restarts the full 12-cycle blackout from that strobe.
- R7: An address outside the window sees `cpu_ready` high in the same cycle, whatever the busy, unsafe, gap and blackout states are. The window is the set of addresses with `(cpu_addr & 16'hFF00) == 16'hFC00` under the default parameters.
- R8: A held window request is granted in the same cycle in which its last blocking condition clears, with no extra wait state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_addr | input | ADDR_W (16) | CPU request address |
| cpu_ready | output | 1 | Request may complete at the next rising edge |
| eng_busy | input | 1 | Engine running sprite or math work, from the system status bit |
| unsafe_sel | input | 1 | External decode: the current address is an unsafe register |
| cart_wr_go | input | 1 | One-cycle strobe: a cartridge write starts |

## Verification
`cpu_ready` is a combinational function of the present inputs and two small registered counters, so its response to the busy, unsafe and address inputs is due in the same cycle. Each check samples 1 ns after the falling edge on which the inputs were driven. The gap shows in the cycle after the accepting rising edge. The blackout covers the strobe cycle and the twelve cycles after it. The bench counts falling edges from the strobe and checks the last blocked cycle and the first free one exactly. The restart case checks cycle 8 after the second strobe, where the first blackout would have ended, to separate a reload from a run-out.

// File: rtl/cop_interlock_pkg.sv
package cop_interlock_pkg;
  typedef struct packed {
    logic engine;
    logic gap;
    logic cart;
  } stall_t;

  function automatic logic any_stall(input stall_t s);
    return s.engine | s.gap | s.cart;
  endfunction
endpackage

// File: rtl/cop_window_decode.sv
module cop_window_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFC00,
  parameter logic [ADDR_W-1:0] WIN_MASK = 16'hFF00
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  assign hit = ((addr & WIN_MASK) == WIN_BASE);
endmodule

// File: rtl/cop_gap_tracker.sv
module cop_gap_tracker #(
  parameter int GAP_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  output logic hold
);
  generate
    if (GAP_CYCLES == 0) begin : g_none
      assign hold = 1'b0;
    end else begin : g_cnt
      localparam int W = $clog2(GAP_CYCLES + 1);
      logic [W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (accept)       cnt <= W'(GAP_CYCLES);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
      end
      assign hold = (cnt != '0);
    end
  endgenerate
endmodule

// File: rtl/cop_blackout_timer.sv
module cop_blackout_timer #(
  parameter int BLACKOUT_CYCLES = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic hold
);
  localparam int W = $clog2(BLACKOUT_CYCLES + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (start)     cnt <= W'(BLACKOUT_CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  // the strobe cycle itself is already blocked
  assign hold = start | (cnt != '0);
endmodule

// File: rtl/cop_bus_interlock.sv
module cop_bus_interlock
  import cop_interlock_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFC00,
  parameter logic [ADDR_W-1:0] WIN_MASK = 16'hFF00,
  parameter int GAP_CYCLES = 1,
  parameter int BLACKOUT_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  input  logic              eng_busy,
  input  logic              unsafe_sel,
  input  logic              cart_wr_go
);
  logic   win_hit;
  logic   gap_hold;
  logic   cart_hold;
  logic   win_accept;
  stall_t why;

  cop_window_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK))
    u_dec (.addr(cpu_addr), .hit(win_hit));

  cop_gap_tracker #(.GAP_CYCLES(GAP_CYCLES))
    u_gap (.clk(clk), .rst(rst), .accept(win_accept), .hold(gap_hold));

  cop_blackout_timer #(.BLACKOUT_CYCLES(BLACKOUT_CYCLES))
    u_cart (.clk(clk), .rst(rst), .start(cart_wr_go), .hold(cart_hold));

  always_comb begin
    why.engine = eng_busy & unsafe_sel;
    why.gap    = gap_hold;
    why.cart   = cart_hold;
  end

  assign cpu_ready  = ~win_hit | ~any_stall(why);
  assign win_accept = cpu_valid & cpu_ready & win_hit;
endmodule

// File: rtl/cop_bus_interlock_chk.sv
module cop_bus_interlock_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFC00,
  parameter logic [ADDR_W-1:0] WIN_MASK = 16'hFF00,
  parameter int BLACKOUT_CYCLES = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_valid,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              eng_busy,
  input logic              unsafe_sel,
  input logic              cart_wr_go
);
  localparam int W = $clog2(BLACKOUT_CYCLES + 1);
  logic         in_win;
  logic [W-1:0] shadow;
  logic         seen_edge;

  assign in_win = ((cpu_addr & WIN_MASK) == WIN_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow    <= '0;
      seen_edge <= 1'b0;
    end else begin
      seen_edge <= 1'b1;
      if (cart_wr_go)          shadow <= W'(BLACKOUT_CYCLES);
      else if (shadow != '0)   shadow <= shadow - 1'b1;
    end
  end

  // R2
  unsafe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && in_win && eng_busy && unsafe_sel) |-> !cpu_ready);

  // R4
  back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_edge && $past(cpu_valid && cpu_ready && in_win) && !$past(rst) && in_win) |-> !cpu_ready);

  // R5
  cart_window_chk: assert property (@(posedge clk) disable iff (rst)
    (in_win && (cart_wr_go || shadow != '0)) |-> !cpu_ready);

  // R7
  outside_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && !in_win) |-> cpu_ready);
endmodule

bind cop_bus_interlock cop_bus_interlock_chk #(
  .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK),
  .BLACKOUT_CYCLES(BLACKOUT_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
  .cpu_ready(cpu_ready), .eng_busy(eng_busy), .unsafe_sel(unsafe_sel),
  .cart_wr_go(cart_wr_go)
);

// File: tb/tb_cop_bus_interlock.sv
module tb_cop_bus_interlock;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_valid = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_ready;
  logic        eng_busy = 1'b0;
  logic        unsafe_sel = 1'b0;
  logic        cart_wr_go = 1'b0;

  int checks = 0;
  int errors = 0;

  localparam logic [15:0] WIN = 16'hFC10;
  localparam logic [15:0] OUT = 16'h1234;

  always #5 clk = ~clk;

  cop_bus_interlock dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .eng_busy(eng_busy), .unsafe_sel(unsafe_sel),
    .cart_wr_go(cart_wr_go)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: cpu_ready=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] a, input logic b,
                       input logic u, input logic c);
    @(negedge clk);
    cpu_valid = v; cpu_addr = a; eng_busy = b; unsafe_sel = u; cart_wr_go = c;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, OUT, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    drive(1'b0, WIN, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    drive(1'b0, WIN, 1'b0, 1'b0, 1'b0);
    check("R1 ready after reset", cpu_ready, 1'b1);
    idle(2);
  endtask

  task automatic t_outside;
    drive(1'b1, OUT, 1'b1, 1'b1, 1'b1);
    check("R7 outside with all blockers", cpu_ready, 1'b1);
    drive(1'b1, OUT, 1'b0, 1'b0, 1'b0);
    check("R7 outside during blackout", cpu_ready, 1'b1);
    idle(14);
  endtask

  task automatic t_unsafe;
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, WIN, 1'b1, 1'b1, 1'b0);
      check("R2 unsafe while busy", cpu_ready, 1'b0);
    end
    drive(1'b1, WIN, 1'b0, 1'b1, 1'b0);
    check("R8 release when busy drops", cpu_ready, 1'b1);
    idle(3);
  endtask

  task automatic t_partial;
    drive(1'b0, WIN, 1'b1, 1'b0, 1'b0);
    check("R3 busy without unsafe", cpu_ready, 1'b1);
    drive(1'b0, WIN, 1'b0, 1'b1, 1'b0);
    check("R3 unsafe without busy", cpu_ready, 1'b1);
    idle(2);
  endtask

  task automatic t_gap;
    drive(1'b1, WIN, 1'b0, 1'b0, 1'b0);
    check("R4 first access", cpu_ready, 1'b1);
    drive(1'b1, WIN, 1'b0, 1'b0, 1'b0);
    check("R4 back-to-back held", cpu_ready, 1'b0);
    cpu_addr = OUT; #1;
    check("R7 outside in gap cycle", cpu_ready, 1'b1);
    cpu_addr = WIN; #1;
    drive(1'b1, WIN, 1'b0, 1'b0, 1'b0);
    check("R4 R8 granted after gap", cpu_ready, 1'b1);
    idle(3);
  endtask

  task automatic t_blackout;
    drive(1'b1, WIN, 1'b0, 1'b0, 1'b1);
    check("R5 strobe cycle", cpu_ready, 1'b0);
    for (int k = 1; k <= 12; k++) begin
      drive(1'b1, WIN, 1'b0, 1'b0, 1'b0);
      check("R5 inside blackout", cpu_ready, 1'b0);
    end
    drive(1'b1, WIN, 1'b0, 1'b0, 1'b0);
    check("R5 R8 free at cycle 13", cpu_ready, 1'b1);
    idle(3);
  endtask

  task automatic t_restart;
    drive(1'b0, WIN, 1'b0, 1'b0, 1'b1);
    for (int k = 1; k < 5; k++) drive(1'b0, WIN, 1'b0, 1'b0, 1'b0);
    drive(1'b0, WIN, 1'b0, 1'b0, 1'b1);
    check("R6 second strobe cycle", cpu_ready, 1'b0);
    for (int j = 1; j <= 12; j++) begin
      drive(1'b0, WIN, 1'b0, 1'b0, 1'b0);
      if (j == 8)  check("R6 past first blackout end", cpu_ready, 1'b0);
      if (j == 12) check("R6 last cycle of restarted blackout", cpu_ready, 1'b0);
    end
    drive(1'b0, WIN, 1'b0, 1'b0, 1'b0);
    check("R6 free 13 after restart", cpu_ready, 1'b1);
    idle(2);
  endtask

  initial begin
    t_reset();
    t_outside();
    t_unsafe();
    t_partial();
    t_gap();
    t_blackout();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule